// File: doc/BRIEF.md
# Low-Half Array Multiplier

This block multiplies two operands of equal width and returns only the lower half of the full product, i.e. the result bits that fit in the operand width. It is purely combinational: the result follows the operands in the same cycle, and nothing is stored. The enclosing datapath selects it as one of its arithmetic functions and places the result on its shared result bus.

The product is built as a carry-save-free array. Each row ANDs operand A with one bit of operand B, shifts the result by that bit's position, and adds it into a running sum with a chain of explicit full-adder cells. Any cell that could only affect product bits at or above the operand width is left out. Row j therefore holds WIDTH − j cells, and the topmost cell of each row keeps only its sum output.

The lower half of a product is the same for unsigned and two's-complement operands. For that reason the block has no sign-correction logic, and a single array serves signed and unsigned multiplication.

Top module: `lohalf_mult`

## Requirements
- R1: `p` equals bits [WIDTH-1:0] of the unsigned product of `a` and `b`, for every pair of operand values.
- R2: When `a` and `b` are read as two's-complement numbers, `p` equals the low WIDTH bits of their signed product. Examples at WIDTH=32: −7 × 6 gives 0xFFFFFFD6 (−42), and −8 × −5 gives 0x00000028 (40).
- R3: Bit 0 of `p` equals `a[0] AND b[0]`.
- R4: If either operand is zero, `p` is zero.
- R5: If `b` is one, `p` equals `a`.
- R6: If `b` is two, `p` is `a` shifted left by one place, and the old top bit of `a` is lost. Examples at WIDTH=32: 0x80000000 × 2 gives 0, 0x7FFFFFFF × 2 gives 0xFFFFFFFE, and 0xFFFFFFFF × 2 gives 0xFFFFFFFE.
- R7: If bit 0 of both `a` and `b` is zero, bits [1:0] of `p` are zero.
- R8: The block has no clock and no storage. A new operand pair shows its result at `p` before the next clock edge of the surrounding logic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Multiplicand, either unsigned or two's complement |
| b | input | WIDTH | Multiplier, either unsigned or two's complement |
| p | output | WIDTH | Low WIDTH bits of a × b |

## Verification
The checker's properties assume that both operands carry known 0/1 values whenever they are evaluated. The checker also assumes that `p` has settled through the whole ripple array by the time a property is checked. The bench meets both conditions. It drives every operand bit from a defined value, from time zero onward. It changes the operands only on a clock edge and samples the result a short delay later, well before the next edge. The bench checks a 6-bit copy of the block over all 4096 operand pairs. It checks the 32-bit block with directed corner cases and with random pairs, and compares each result against a product it computes arithmetically.

// File: rtl/lohalf_mult_pkg.sv
package lohalf_mult_pkg;

    // Sum bit of a full adder cell
    function automatic logic fa_sum(input logic x, input logic y, input logic ci);
        return x ^ y ^ ci;
    endfunction

    // Carry bit of a full adder cell
    function automatic logic fa_carry(input logic x, input logic y, input logic ci);
        return (x & y) | (ci & (x ^ y));
    endfunction

endpackage

// File: rtl/lohalf_mult_fa.sv
module lohalf_mult_fa
    import lohalf_mult_pkg::*;
(
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = fa_sum(x, y, ci);
    assign co = fa_carry(x, y, ci);
endmodule

// File: rtl/lohalf_mult_sumcell.sv
// Topmost cell of a row: its carry would land above the kept half.
module lohalf_mult_sumcell
    import lohalf_mult_pkg::*;
(
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s
);
    assign s = fa_sum(x, y, ci);
endmodule

// File: rtl/lohalf_mult_row.sv
// One accumulation row: adds (a & b_bit) << SHIFT into acc_in.
module lohalf_mult_row #(
    parameter int WIDTH = 32,
    parameter int SHIFT = 1
) (
    input  logic [WIDTH-1:0]       acc_in,
    input  logic [WIDTH-SHIFT-1:0] a_lo,
    input  logic                   b_bit,
    output logic [WIDTH-1:0]       acc_out
);
    localparam int CELLS = WIDTH - SHIFT;

    logic [CELLS-1:0] pp;
    logic [CELLS-1:0] carry;

    assign pp       = a_lo & {CELLS{b_bit}};
    assign carry[0] = 1'b0;

    // Bits below SHIFT receive nothing from this row
    assign acc_out[SHIFT-1:0] = acc_in[SHIFT-1:0];

    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        if (k < CELLS - 1) begin : g_full
            lohalf_mult_fa u_fa (
                .x  (acc_in[SHIFT+k]),
                .y  (pp[k]),
                .ci (carry[k]),
                .s  (acc_out[SHIFT+k]),
                .co (carry[k+1])
            );
        end else begin : g_top
            lohalf_mult_sumcell u_top (
                .x  (acc_in[SHIFT+k]),
                .y  (pp[k]),
                .ci (carry[k]),
                .s  (acc_out[SHIFT+k])
            );
        end
    end
endmodule

// File: rtl/lohalf_mult.sv
module lohalf_mult #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] p
);
    localparam int ROWS = WIDTH;

    logic [WIDTH-1:0] acc [ROWS];

    // Row 0 is the bare partial product: no adders needed
    assign acc[0] = a & {WIDTH{b[0]}};

    for (genvar j = 1; j < ROWS; j++) begin : g_row
        lohalf_mult_row #(
            .WIDTH (WIDTH),
            .SHIFT (j)
        ) u_row (
            .acc_in  (acc[j-1]),
            .a_lo    (a[WIDTH-1-j:0]),
            .b_bit   (b[j]),
            .acc_out (acc[j])
        );
    end

    assign p = acc[ROWS-1];
endmodule

// File: rtl/lohalf_mult_chk.sv
module lohalf_mult_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] p
);
    always_comb begin
        // R3
        a_r3_lsb_and: assert (p[0] == (a[0] & b[0]))
            else $error("R3: p[0] mismatch");
        // R4
        if (a == '0 || b == '0) begin
            a_r4_zero_operand: assert (p == '0)
                else $error("R4: zero operand gave nonzero p");
        end
        // R5
        if (b == WIDTH'(1)) begin
            a_r5_unit_mult: assert (p == a)
                else $error("R5: b==1 did not pass a");
        end
        // R6
        if (b == WIDTH'(2)) begin
            a_r6_double: assert (p == {a[WIDTH-2:0], 1'b0})
                else $error("R6: b==2 not a left shift");
        end
        // R7
        if (!a[0] && !b[0]) begin
            a_r7_even_even: assert (p[1:0] == 2'b00)
                else $error("R7: low bits of even*even nonzero");
        end
    end
endmodule

bind lohalf_mult lohalf_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .a (a),
    .b (b),
    .p (p)
);

// File: tb/lohalf_mult_bench.sv
`timescale 1ns/1ps
module lohalf_mult_bench;
    localparam int W  = 32;
    localparam int WS = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [W-1:0]  a, b, p;
    logic [WS-1:0] sa, sb, sp;

    int vectors     = 0;
    int miscompares = 0;
    int cycles      = 0;
    bit done        = 1'b0;

    lohalf_mult #(.WIDTH(W))  u_lohalf_mult       (.a(a),  .b(b),  .p(p));
    lohalf_mult #(.WIDTH(WS)) u_lohalf_mult_small (.a(sa), .b(sb), .p(sp));

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic check32(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        vectors = vectors + 1;
        if (got !== exp) begin
            miscompares = miscompares + 1;
            $display("FAIL %s: a=%h b=%h got %h expected %h", tag, a, b, got, exp);
        end
    endtask

    // Drive at an edge, sample 2 ns later (before the next edge): R8
    task automatic apply32(input string tag, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [63:0] full;
        @(posedge clk);
        a = x;
        b = y;
        full = {32'b0, x} * {32'b0, y};
        #2;
        check32(tag, p, full[W-1:0]);
    endtask

    task automatic apply_signed(input string tag, input int x, input int y);
        longint prod;
        @(posedge clk);
        a = x;
        b = y;
        prod = longint'(x) * longint'(y);
        #2;
        check32(tag, p, prod[W-1:0]);
    endtask

    initial begin
        a  = '0;
        b  = '0;
        sa = '0;
        sb = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #2;
        check32("R4 idle zero", p, '0);

        // R2 signed directed
        apply_signed("R2 -7x6", -7, 6);
        apply_signed("R2 -8x-5", -8, -5);
        apply_signed("R2 min x -1", 32'sh80000000, -1);
        // R6 doubling corners
        apply32("R6 all-ones x2", 32'hFFFFFFFF, 32'd2);
        apply32("R6 min x2", 32'h80000000, 32'd2);
        apply32("R6 max x2", 32'h7FFFFFFF, 32'd2);
        // R5 / R4
        apply32("R5 b one", 32'hDEADBEEF, 32'd1);
        apply32("R4 a zero", 32'd0, 32'hCAFEF00D);
        apply32("R4 b zero", 32'h12345678, 32'd0);
        // R1 unsigned patterns
        apply32("R1 ones x ones", 32'hFFFFFFFF, 32'hFFFFFFFF);
        apply32("R1 alt bits", 32'hAAAAAAAA, 32'h55555555);
        apply32("R1 powers", 32'h00010000, 32'h00010000);
        // R3 / R7
        apply32("R3 odd x odd", 32'h00000003, 32'h00000005);
        apply32("R7 even x even", 32'h00000006, 32'h0000000A);

        // R8: result changes with no clock edge in between
        @(posedge clk);
        a = 32'd9; b = 32'd9;
        #1;
        check32("R8 first", p, 32'd81);
        a = 32'd12;
        #1;
        check32("R8 same cycle", p, 32'd108);

        // R1 / R2 random pairs, unsigned and signed reference
        for (int i = 0; i < 1200; i++) begin
            if (i % 2 == 0)
                apply32("R1 random", $urandom, $urandom);
            else
                apply_signed("R2 random", $urandom, $urandom);
        end

        // R1 exhaustive sweep of the 6-bit copy
        for (int x = 0; x < (1 << WS); x++) begin
            for (int y = 0; y < (1 << WS); y++) begin
                logic [2*WS-1:0] sfull;
                @(posedge clk);
                sa = WS'(x);
                sb = WS'(y);
                sfull = {{WS{1'b0}}, WS'(x)} * {{WS{1'b0}}, WS'(y)};
                #2;
                vectors = vectors + 1;
                if (sp !== sfull[WS-1:0]) begin
                    miscompares = miscompares + 1;
                    $display("FAIL R1 sweep: a=%0d b=%0d got %h expected %h",
                             x, y, sp, sfull[WS-1:0]);
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule